// File: doc/BRIEF.md
# Masked Local-Bus Interrupt Controller

This block gathers up to sixteen level-sensitive interrupt lines from peripherals on a local bus and combines them into a single request line toward the processor. Each input is copied into a source register every clock. A software-writable enable mask selects which sources may contribute. The combined request is high whenever at least one source is both active and enabled.

Software sees two 16-bit registers through a simple synchronous bus with byte enables. The vector register is read-only. It returns a small encoded number for the lowest-numbered active, enabled source, so an interrupt handler can dispatch on it directly instead of scanning a bitmap. The mask register can be read and written, one byte lane or both at a time. The interrupt inputs are synchronous to the block clock. A peripheral clears its request by dropping its line; there is no separate acknowledge.

The bus address is a halfword index: index 0 is the vector register and index 1 is the mask register. Read data and the error strobe appear one cycle after the read is presented.

Top module: `lbirq_ctrl`

## Requirements
- R1: Source bit i equals the level that input `irq_in[i]` had on the previous clock edge; it is set while the line is high and cleared once it drops.
- R2: `irq_out` is high exactly when (source AND mask) is nonzero. It follows a change of an input or of the mask one clock later.
- R3: A read at index 0 returns ((i+1)<<2) in bits [15:0] for the lowest-numbered set bit i of (source AND mask), or 0 when none is set. This gives 0x0004 for source 0 and 0x0040 for source 15.
- R4: A read at index 1 returns the mask. A write at index 1 updates the mask, and the new value takes effect from the next cycle.
- R5: Writes at index 0 are ignored: the mask and the vector read afterwards are unchanged.
- R6: `bus_be[0]` enables bits [7:0] and `bus_be[1]` enables bits [15:8] of a mask write. A lane whose enable is low keeps its current value.
- R7: After reset the mask is 0x0010, the source register is 0 and `irq_out` is low. With that mask, input 4 alone raises `irq_out` and reads back as vector 0x0014.
- R8: A read at index 2 to 7 returns 0 and pulses `bus_err` high for exactly one cycle. Mapped reads never raise `bus_err`, and writes at index 2 to 7 change nothing.
- R9: A source whose mask bit is 0 affects neither `irq_out` nor the vector, even when it is the lowest-numbered active line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 16 | Level interrupt lines, synchronous to clk |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Halfword register index |
| bus_be | input | 2 | Byte-lane enables for writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after a read |
| bus_err | output | 1 | One-cycle strobe after a read of an unmapped index |
| irq_out | output | 1 | Combined interrupt request |

## Verification
A source bit that is stuck or stale shows up as a wrong `irq_out` level one cycle after the input edge, and as a wrong vector on the next read of index 0. A corrupted mask lane shows in the mask readback one cycle after the write. It also shows as a request that is wrongly raised or dropped for the sources that lane covers. Faults in priority selection only appear when several enabled sources are active together, so the stimulus uses patterns that mix the lowest line, the highest line and masked lower lines.

// File: rtl/lbirq_pkg.sv
package lbirq_pkg;

  localparam int MAX_SRC = 32;

  // Vector for the lowest-numbered set bit: (index+1) << 2, zero if none set.
  function automatic logic [15:0] vec_encode(input logic [MAX_SRC-1:0] pend);
    logic [15:0] r;
    r = '0;
    for (int i = MAX_SRC - 1; i >= 0; i--) begin
      if (pend[i]) r = 16'((i + 1) << 2);
    end
    return r;
  endfunction

endpackage

// File: rtl/lbirq_src.sv
module lbirq_src #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines,
  input  logic [N-1:0] enable,
  output logic [N-1:0] src_q,
  output logic [N-1:0] pending,
  output logic         any_pending
);
  always_ff @(posedge clk) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= lines;
  end

  assign pending     = src_q & enable;
  assign any_pending = |pending;
endmodule

// File: rtl/lbirq_vec_enc.sv
module lbirq_vec_enc #(
  parameter int N      = 16,
  parameter int DATA_W = 16
) (
  input  logic [N-1:0]      pending,
  output logic [DATA_W-1:0] vec
);
  import lbirq_pkg::*;

  logic [MAX_SRC-1:0] pend_ext;
  assign pend_ext = MAX_SRC'(pending);
  assign vec      = DATA_W'(vec_encode(pend_ext));
endmodule

// File: rtl/lbirq_regif.sv
module lbirq_regif #(
  parameter int              DATA_W   = 16,
  parameter int              ADDR_W   = 3,
  parameter logic [DATA_W-1:0] MASK_RST = 16'h0010
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel,
  input  logic                wr,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W/8-1:0] be,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W-1:0]   vec,
  output logic [DATA_W-1:0]   mask_q,
  output logic [DATA_W-1:0]   rdata,
  output logic                err,
  output logic                mask_wr_ev,
  output logic                rd_unmapped_ev
);
  localparam int BE_W = DATA_W / 8;
  localparam logic [ADDR_W-1:0] VEC_IDX  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] MASK_IDX = ADDR_W'(1);

  function automatic logic [DATA_W-1:0] lane_merge(
    input logic [DATA_W-1:0] old_v,
    input logic [DATA_W-1:0] new_v,
    input logic [BE_W-1:0]   lanes);
    logic [DATA_W-1:0] r;
    for (int b = 0; b < BE_W; b++)
      r[b*8 +: 8] = lanes[b] ? new_v[b*8 +: 8] : old_v[b*8 +: 8];
    return r;
  endfunction

  logic hit_vec, hit_mask, rd_ev;
  assign hit_vec        = (addr == VEC_IDX);
  assign hit_mask       = (addr == MASK_IDX);
  assign rd_ev          = sel && !wr;
  assign mask_wr_ev     = sel && wr && hit_mask;
  assign rd_unmapped_ev = rd_ev && !hit_vec && !hit_mask;

  always_ff @(posedge clk) begin
    if (!rst_n)          mask_q <= MASK_RST;
    else if (mask_wr_ev) mask_q <= lane_merge(mask_q, wdata, be);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      err <= rd_unmapped_ev;
      if (rd_ev) begin
        if (hit_vec)       rdata <= vec;
        else if (hit_mask) rdata <= mask_q;
        else               rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/lbirq_ctrl.sv
module lbirq_ctrl #(
  parameter int                N        = 16,
  parameter int                DATA_W   = 16,
  parameter int                ADDR_W   = 3,
  parameter logic [DATA_W-1:0] MASK_RST = 16'h0010
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        irq_in,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                bus_err,
  output logic                irq_out
);
  logic [DATA_W-1:0] mask_q;
  logic [N-1:0]      src_q, pending;
  logic              any_pending;
  logic [DATA_W-1:0] vec;
  logic              mask_wr_ev, rd_unmapped_ev;

  lbirq_src #(.N(N)) u_src (
    .clk(clk), .rst_n(rst_n), .lines(irq_in), .enable(mask_q[N-1:0]),
    .src_q(src_q), .pending(pending), .any_pending(any_pending)
  );

  lbirq_vec_enc #(.N(N), .DATA_W(DATA_W)) u_enc (
    .pending(pending), .vec(vec)
  );

  lbirq_regif #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .MASK_RST(MASK_RST)) u_regif (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .be(bus_be), .wdata(bus_wdata), .vec(vec), .mask_q(mask_q),
    .rdata(bus_rdata), .err(bus_err), .mask_wr_ev(mask_wr_ev),
    .rd_unmapped_ev(rd_unmapped_ev)
  );

  assign irq_out = any_pending;
endmodule

// File: rtl/lbirq_chk.sv
module lbirq_chk #(
  parameter int                N        = 16,
  parameter int                DATA_W   = 16,
  parameter int                ADDR_W   = 3,
  parameter logic [DATA_W-1:0] MASK_RST = 16'h0010
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N-1:0]        irq_in,
  input logic                bus_sel,
  input logic                bus_wr,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic                bus_err,
  input logic                irq_out,
  input logic [N-1:0]        src_q,
  input logic [DATA_W-1:0]   mask_q,
  input logic                mask_wr_ev,
  input logic                rd_unmapped_ev
);
  // R1
  src_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> src_q == $past(irq_in));

  // R2
  out_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> irq_out == (($past(irq_in) & mask_q[N-1:0]) != '0));

  // R5
  vec_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == '0) |=> $stable(mask_q));

  // R7
  reset_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mask_q == MASK_RST && !irq_out));

  // R8
  err_only_unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> ($past(rst_n) && $past(bus_sel && !bus_wr && bus_addr > ADDR_W'(1))));

  // R8
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_unmapped_ev |=> (bus_err && bus_rdata == '0));

  // R3
  vec_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == '0 && (src_q & mask_q[N-1:0]) == '0)
      |=> bus_rdata == '0);

  // R4
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr_ev |=> $stable(mask_q));
endmodule

bind lbirq_ctrl lbirq_chk #(.N(N), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MASK_RST(MASK_RST)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .bus_err(bus_err), .irq_out(irq_out),
  .src_q(src_q), .mask_q(mask_q), .mask_wr_ev(mask_wr_ev), .rd_unmapped_ev(rd_unmapped_ev)
);

// File: tb/sim_lbirq_ctrl.sv
module sim_lbirq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_in = '0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [1:0]  bus_be = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_err, irq_out;

  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lbirq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .irq_out(irq_out)
  );

  // {irq_in, mask, expected vector, expected irq_out}
  localparam logic [48:0] TBL [0:7] = '{
    {16'h0001, 16'hFFFF, 16'h0004, 1'b1},
    {16'h8000, 16'hFFFF, 16'h0040, 1'b1},
    {16'h8001, 16'hFFFE, 16'h0040, 1'b1},
    {16'h0000, 16'hFFFF, 16'h0000, 1'b0},
    {16'h00F0, 16'h0020, 16'h0018, 1'b1},
    {16'hFFFF, 16'h0000, 16'h0000, 1'b0},
    {16'h0030, 16'h0030, 16'h0014, 1'b1},
    {16'h0100, 16'h0010, 16'h0000, 1'b0}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [15:0] d, output logic e);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata; e = bus_err;
  endtask

  initial begin
    logic [15:0] d;
    logic e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state
    chk("R7 irq_out after reset", {15'b0, irq_out}, 16'h0);
    rd_reg(3'd1, d, e);  chk("R7 mask reset value", d, 16'h0010);
    rd_reg(3'd0, d, e);  chk("R7 source cleared, vector", d, 16'h0000);
    irq_in = 16'h0010;
    @(negedge clk);
    chk("R7 default mask passes source 4", {15'b0, irq_out}, 16'h1);
    rd_reg(3'd0, d, e);  chk("R7 vector for source 4", d, 16'h0014);
    irq_in = 16'h0;
    @(negedge clk);
    chk("R1 source drops with line", {15'b0, irq_out}, 16'h0);

    // R3 R9 R2 table walk
    for (int k = 0; k < 8; k++) begin
      wr_reg(3'd1, 2'b11, TBL[k][32:17]);
      irq_in = TBL[k][48:33];
      @(negedge clk);
      chk($sformatf("R2 irq_out row %0d", k), {15'b0, irq_out}, {15'b0, TBL[k][0]});
      rd_reg(3'd0, d, e);
      chk($sformatf("R3 R9 vector row %0d", k), d, TBL[k][16:1]);
    end

    // R2 one-cycle latency on input change
    wr_reg(3'd1, 2'b11, 16'h0004);
    irq_in = 16'h0004;
    chk("R2 before edge", {15'b0, irq_out}, 16'h0);
    @(negedge clk);
    chk("R2 one cycle after input", {15'b0, irq_out}, 16'h1);
    wr_reg(3'd1, 2'b11, 16'h0000);
    chk("R2 after mask cleared", {15'b0, irq_out}, 16'h0);
    irq_in = 16'h0;

    // R4 R6 mask readback and byte lanes
    wr_reg(3'd1, 2'b11, 16'h1234);
    rd_reg(3'd1, d, e);  chk("R4 mask readback", d, 16'h1234);
    wr_reg(3'd1, 2'b01, 16'h77AB);
    rd_reg(3'd1, d, e);  chk("R6 low lane only", d, 16'h12AB);
    wr_reg(3'd1, 2'b10, 16'hCD99);
    rd_reg(3'd1, d, e);  chk("R6 high lane only", d, 16'hCDAB);

    // R5 write to vector index ignored
    wr_reg(3'd0, 2'b11, 16'hFFFF);
    rd_reg(3'd1, d, e);  chk("R5 mask unchanged", d, 16'hCDAB);
    rd_reg(3'd0, d, e);  chk("R5 vector unchanged", d, 16'h0000);

    // R8 unmapped accesses
    rd_reg(3'd2, d, e);
    chk("R8 unmapped read data", d, 16'h0000);
    chk("R8 err strobe", {15'b0, e}, 16'h1);
    @(negedge clk);
    chk("R8 err one cycle", {15'b0, bus_err}, 16'h0);
    rd_reg(3'd1, d, e);  chk("R8 mapped read no err", {15'b0, e}, 16'h0);
    wr_reg(3'd7, 2'b11, 16'h0000);
    rd_reg(3'd1, d, e);  chk("R8 unmapped write no effect", d, 16'hCDAB);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule